// File: doc/BRIEF.md
# Transcoder Reset and Initialization Sequencer

This block manages the start-up and per-channel set-up timing of a multichannel voice transcoder. It filters the active-low reset input so that glitches are rejected and treats a power-on reset exactly like an accepted external reset. When reset is released it walks a state-memory clear for a fixed number of clocks, producing a write enable and an address. It then holds the rest of the chip idle until the channel strobe `ce` falls, and at that moment it issues a one-cycle resume strobe.

While running, every falling edge of `ce` latches the channel configuration and an initialization request. The block also watches three timing rules and raises sticky flags when any of them is broken. The first is the minimum reset width. The second is strobe activity inside a guard window right after release. The third is the strobe period of a slot that carried an initialization request.

All inputs are sampled on the rising edge of `clk`. All outputs come from registers, except `clr_en`, `clr_addr` and `busy`, which are decoded from registers.

Top module: `xcode_init_seq`

## Requirements
- R1: When `rst_n` is sampled low on two consecutive clock edges, the block enters reset at the second of those edges. In reset, `busy`=1, `clr_en`=0, `resume`=0, and both error flags are cleared.
- R2: A reset pulse seen low on only one clock edge is ignored. `busy`, the captured configuration and both error flags keep their values.
- R3: The release edge is the first edge where `rst_n` is sampled high after an accepted reset. From that edge, `clr_en` is 1 for exactly 726 cycles, and `clr_addr` steps 0, 1, … 725, one step per clock.
- R4: After clearing ends, `busy` stays 1 until the first falling edge of `ce`. A falling edge of `ce` means `ce` was sampled 1 on one edge and 0 on the next. On that edge `resume` pulses for one cycle and `busy` drops in the same cycle. A `ce` fall during clearing does not resume.
- R5: A change of `ce` level sampled at any of the first 6 clock edges after the release edge sets `err_ce_early`. A change sampled at the 7th edge or later does not set it.
- R6: A `ce` fall or an `init_req` that arrives while clearing or waiting is discarded: `init_fire` stays 0, and the clear address sequence is not disturbed.
- R7: On each `ce` fall that resumes or occurs while running, `cfg_law`, `cfg_en` and `cfg_mode` appear on `init_law`, `init_en` and `init_mode` from the next cycle. In that same next cycle, `init_fire` is 1 for one cycle exactly when `init_req` was 1.
- R8: A slot starts at a `ce` fall that captured `init_req`=1. That slot must last exactly 45 clock edges until the next `ce` fall, or `err_slot` is set. Slots without a request may have any length. `err_slot` stays set until the next accepted reset.
- R9: Driving `por_n` low puts the block into the reset state at once, without waiting for a clock. After `por_n` rises, the first edge with `rst_n` high is a release edge.
- R10: `busy` is 1 from an accepted reset or power-on reset until the `resume` cycle. `clr_en` is never 1 while `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | External reset, active low, width-filtered |
| ce | input | 1 | Channel slot strobe |
| init_req | input | 1 | Per-channel initialization request |
| cfg_law | input | 1 | PCM companding law select |
| cfg_en | input | 1 | Channel enable |
| cfg_mode | input | 2 | Coding rate select |
| clr_en | output | 1 | State memory clear write enable |
| clr_addr | output | ADDR_W (10) | State memory clear address |
| busy | output | 1 | Reset, clear or wait-for-strobe in progress |
| resume | output | 1 | One-cycle strobe: normal processing starts |
| init_fire | output | 1 | One-cycle strobe: channel initialization requested |
| init_law | output | 1 | Captured companding law |
| init_en | output | 1 | Captured channel enable |
| init_mode | output | 2 | Captured coding rate |
| err_ce_early | output | 1 | Sticky: strobe moved inside the guard window |
| err_slot | output | 1 | Sticky: initialization slot length wrong |

## Verification
Every output is a register or a decode of one, so each result is due in the cycle after the sampling edge that causes it. An accepted reset shows at the second low edge. The clear enable appears one cycle after the release edge and lasts 726 cycles. `resume`, `init_fire`, the captured fields and the error flags all appear one cycle after the responsible `ce` edge. The bench drives inputs and compares against its reference model only on falling clock edges. The model advances on the same rising edges as the design, so each comparison lands in the first cycle where a new value is due. Directed checks count edges from the release edge to hit the 6th and 7th guard-window edges and slot periods of 44, 45 and 46.

// File: rtl/xinit_pkg.sv
package xinit_pkg;

  typedef enum logic [1:0] {
    PH_RESET = 2'd0,
    PH_CLEAR = 2'd1,
    PH_WAIT  = 2'd2,
    PH_RUN   = 2'd3
  } phase_t;

  typedef struct packed {
    logic       law;
    logic       en;
    logic [1:0] mode;
  } chan_cfg_t;

  // strobe fell between the previous sample and the current one
  function automatic logic strobe_fell(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  // strobe changed level between two samples
  function automatic logic strobe_moved(input logic prev, input logic cur);
    return prev ^ cur;
  endfunction

  // true while a step count still lies inside a guard window
  function automatic logic in_guard(input int step, input int guard);
    return step < guard;
  endfunction

endpackage

// File: rtl/xinit_rst_filt.sv
module xinit_rst_filt #(
  parameter int MIN_LOW = 2,
  localparam int LW = $clog2(MIN_LOW + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_n,
  output logic acc,
  output logic rel
);

  localparam logic [LW-1:0] LOW_MAX = LW'(MIN_LOW);

  logic [LW-1:0] low_cnt;

  // consecutive low samples, saturating; power-on counts as a full-width pulse
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                low_cnt <= LOW_MAX;
    else if (rst_n)            low_cnt <= '0;
    else if (low_cnt != LOW_MAX) low_cnt <= low_cnt + 1'b1;
  end

  // this low sample brings the run to the minimum width
  assign acc = !rst_n && (low_cnt >= LOW_MAX - 1'b1);
  // first high sample after an accepted pulse
  assign rel = rst_n && (low_cnt == LOW_MAX);

endmodule

// File: rtl/xinit_clr_seq.sv
module xinit_clr_seq
  import xinit_pkg::*;
#(
  parameter int CLR_CYCLES = 726,
  parameter int CE_GUARD   = 6,
  localparam int AW = $clog2(CLR_CYCLES)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          start,
  input  logic          active,
  input  logic          ce_edge,
  output logic [AW-1:0] addr,
  output logic          last,
  output logic          early
);

  localparam logic [AW-1:0] LAST_ADDR = AW'(CLR_CYCLES - 1);

  logic [AW-1:0] step;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      step <= '0;
    else if (start)  step <= '0;
    else if (active) step <= step + 1'b1;
  end

  assign addr  = active ? step : '0;
  assign last  = active && (step == LAST_ADDR);
  assign early = active && ce_edge && in_guard(int'(step), CE_GUARD);

endmodule

// File: rtl/xinit_slot_mon.sv
module xinit_slot_mon
  import xinit_pkg::*;
#(
  parameter int SLOT_CLKS = 45,
  localparam int PW = $clog2(SLOT_CLKS + 1) + 1
) (
  input  logic      clk,
  input  logic      por_n,
  input  logic      clr,
  input  logic      take,
  input  logic      init_req,
  input  chan_cfg_t cfg_in,
  output logic      fire,
  output chan_cfg_t cfg_q,
  output logic      bad
);

  localparam logic [PW-1:0] PER_MAX  = '1;
  localparam logic [PW-1:0] PER_GOOD = PW'(SLOT_CLKS);

  logic [PW-1:0] per;
  logic          ipend;

  function automatic logic [PW-1:0] sat_step(input logic [PW-1:0] v);
    return (v == PER_MAX) ? v : v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      per   <= '0;
      ipend <= 1'b0;
      cfg_q <= '0;
      fire  <= 1'b0;
    end else begin
      fire <= take && init_req;
      if (clr) begin
        per   <= '0;
        ipend <= 1'b0;
        cfg_q <= '0;
      end else if (take) begin
        per   <= PW'(1);
        ipend <= init_req;
        cfg_q <= cfg_in;
      end else begin
        per   <= sat_step(per);
      end
    end
  end

  // slot closing now began with a request and has the wrong length
  assign bad = take && ipend && (per != PER_GOOD);

endmodule

// File: rtl/xcode_init_seq.sv
module xcode_init_seq
  import xinit_pkg::*;
#(
  parameter int MIN_LOW    = 2,
  parameter int CLR_CYCLES = 726,
  parameter int CE_GUARD   = 6,
  parameter int SLOT_CLKS  = 45,
  localparam int ADDR_W = $clog2(CLR_CYCLES)
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              init_req,
  input  logic              cfg_law,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_mode,
  output logic              clr_en,
  output logic [ADDR_W-1:0] clr_addr,
  output logic              busy,
  output logic              resume,
  output logic              init_fire,
  output logic              init_law,
  output logic              init_en,
  output logic [1:0]        init_mode,
  output logic              err_ce_early,
  output logic              err_slot
);

  phase_t    ph;
  logic      ce_q;
  logic      resume_q;
  logic      e_early_q;
  logic      e_slot_q;

  // named internal events
  logic      rst_acc;
  logic      rst_rel;
  logic      ce_edge;
  logic      ce_fall;
  logic      clr_last;
  logic      ce_early;
  logic      slot_take;
  logic      slot_bad;
  chan_cfg_t cfg_in;
  chan_cfg_t cfg_cap;

  assign ce_edge   = strobe_moved(ce_q, ce);
  assign ce_fall   = strobe_fell(ce_q, ce);
  assign slot_take = ce_fall && (ph == PH_WAIT || ph == PH_RUN) && !rst_acc;
  assign cfg_in    = '{law: cfg_law, en: cfg_en, mode: cfg_mode};

  xinit_rst_filt #(.MIN_LOW(MIN_LOW)) u_filt (
    .clk   (clk),
    .por_n (por_n),
    .rst_n (rst_n),
    .acc   (rst_acc),
    .rel   (rst_rel)
  );

  xinit_clr_seq #(.CLR_CYCLES(CLR_CYCLES), .CE_GUARD(CE_GUARD)) u_clr (
    .clk     (clk),
    .por_n   (por_n),
    .start   (rst_rel),
    .active  (ph == PH_CLEAR),
    .ce_edge (ce_edge),
    .addr    (clr_addr),
    .last    (clr_last),
    .early   (ce_early)
  );

  xinit_slot_mon #(.SLOT_CLKS(SLOT_CLKS)) u_slot (
    .clk      (clk),
    .por_n    (por_n),
    .clr      (rst_acc),
    .take     (slot_take),
    .init_req (init_req),
    .cfg_in   (cfg_in),
    .fire     (init_fire),
    .cfg_q    (cfg_cap),
    .bad      (slot_bad)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ph        <= PH_RESET;
      ce_q      <= 1'b0;
      resume_q  <= 1'b0;
      e_early_q <= 1'b0;
      e_slot_q  <= 1'b0;
    end else begin
      ce_q     <= ce;
      resume_q <= (ph == PH_WAIT) && ce_fall && !rst_acc;
      if (rst_acc) begin
        ph        <= PH_RESET;
        e_early_q <= 1'b0;
        e_slot_q  <= 1'b0;
      end else begin
        e_early_q <= e_early_q | ce_early;
        e_slot_q  <= e_slot_q | slot_bad;
        if (rst_rel) begin
          ph <= PH_CLEAR;
        end else begin
          case (ph)
            PH_CLEAR: if (clr_last) ph <= PH_WAIT;
            PH_WAIT:  if (ce_fall)  ph <= PH_RUN;
            default:  ph <= ph;
          endcase
        end
      end
    end
  end

  assign clr_en       = (ph == PH_CLEAR);
  assign busy         = (ph != PH_RUN);
  assign resume       = resume_q;
  assign init_law     = cfg_cap.law;
  assign init_en      = cfg_cap.en;
  assign init_mode    = cfg_cap.mode;
  assign err_ce_early = e_early_q;
  assign err_slot     = e_slot_q;

endmodule

// File: rtl/xcode_init_chk.sv
module xcode_init_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          por_n,
  input logic          acc,
  input logic          clr_en,
  input logic [AW-1:0] clr_addr,
  input logic          busy,
  input logic          resume,
  input logic          init_fire,
  input logic          err_ce_early,
  input logic          err_slot
);

  AST_ACC_ENTERS_RESET: assert property (@(posedge clk) disable iff (!por_n)
    acc |=> (busy && !clr_en && !err_ce_early && !err_slot)); // R1

  AST_CLR_FIRST_ADDR: assert property (@(posedge clk) disable iff (!por_n)
    $rose(clr_en) |-> (clr_addr == '0)); // R3

  AST_CLR_ADDR_STEP: assert property (@(posedge clk) disable iff (!por_n)
    (clr_en && $past(clr_en)) |-> (clr_addr == $past(clr_addr) + 1'b1)); // R3

  AST_RESUME_DROPS_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    resume |-> (!busy && $past(busy))); // R4

  AST_RESUME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!por_n)
    resume |=> !resume); // R4

  AST_NO_FIRE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    init_fire |-> !busy); // R6

  AST_SLOT_ERR_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    ($past(err_slot) && !$past(acc)) |-> err_slot); // R8

  AST_CLR_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!por_n)
    clr_en |-> busy); // R10

endmodule

bind xcode_init_seq xcode_init_chk #(.AW(ADDR_W)) u_chk (
  .clk          (clk),
  .por_n        (por_n),
  .acc          (rst_acc),
  .clr_en       (clr_en),
  .clr_addr     (clr_addr),
  .busy         (busy),
  .resume       (resume),
  .init_fire    (init_fire),
  .err_ce_early (err_ce_early),
  .err_slot     (err_slot)
);

// File: tb/tb_xcode_init_seq.sv
module tb_xcode_init_seq;

  logic       clk = 1'b0;
  logic       por_n, rst_n, ce, init_req, cfg_law, cfg_en;
  logic [1:0] cfg_mode;
  logic       clr_en, busy, resume, init_fire, init_law, init_en;
  logic       err_ce_early, err_slot;
  logic [1:0] init_mode;
  logic [9:0] clr_addr;

  always #4 clk = ~clk;

  xcode_init_seq dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ce(ce), .init_req(init_req),
    .cfg_law(cfg_law), .cfg_en(cfg_en), .cfg_mode(cfg_mode),
    .clr_en(clr_en), .clr_addr(clr_addr), .busy(busy), .resume(resume),
    .init_fire(init_fire), .init_law(init_law), .init_en(init_en),
    .init_mode(init_mode), .err_ce_early(err_ce_early), .err_slot(err_slot)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // reference model state: phase 0 reset, 1 clearing, 2 waiting, 3 running
  int m_ph, m_low, m_cnt, m_ceq, m_per, m_ipend;
  int m_res, m_fire, m_law, m_en, m_mode, m_ee, m_es;

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_ph = 0; m_low = 2; m_cnt = 0; m_ceq = 0; m_per = 0; m_ipend = 0;
    m_res = 0; m_fire = 0; m_law = 0; m_en = 0; m_mode = 0; m_ee = 0; m_es = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!por_n) begin
      model_reset();
    end else begin : step
      bit e_edge, e_fall, e_acc, e_rel, e_take, e_early, e_bad, e_last;
      e_edge  = (int'(ce) != m_ceq);
      e_fall  = (m_ceq == 1) && !ce;
      e_acc   = !rst_n && (m_low >= 1);
      e_rel   = rst_n && (m_low >= 2);
      e_take  = e_fall && (m_ph == 2 || m_ph == 3) && !e_acc;
      e_early = (m_ph == 1) && (m_cnt < 6) && e_edge;
      e_bad   = e_take && (m_ipend == 1) && (m_per != 45);
      e_last  = (m_ph == 1) && (m_cnt == 725);
      m_low   = rst_n ? 0 : ((m_low < 2) ? m_low + 1 : 2);
      m_res   = (m_ph == 2) && e_fall && !e_acc;
      m_fire  = e_take && init_req;
      if (e_acc) begin
        m_per = 0; m_ipend = 0; m_law = 0; m_en = 0; m_mode = 0; m_ee = 0; m_es = 0;
      end else begin
        if (e_take) begin
          m_per = 1; m_ipend = init_req; m_law = cfg_law; m_en = cfg_en; m_mode = cfg_mode;
        end else begin
          m_per++;
        end
        if (e_early) m_ee = 1;
        if (e_bad)   m_es = 1;
      end
      if (e_rel) m_cnt = 0;
      else if (m_ph == 1) m_cnt++;
      if (e_acc)                  m_ph = 0;
      else if (e_rel)             m_ph = 1;
      else if (e_last)            m_ph = 2;
      else if (m_ph == 2 && e_fall) m_ph = 3;
      m_ceq = ce;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (por_n) begin
      chk("R3",  "clr_en",       clr_en,       m_ph == 1);
      chk("R3",  "clr_addr",     clr_addr,     (m_ph == 1) ? m_cnt : 0);
      chk("R10", "busy",         busy,         m_ph != 3);
      chk("R4",  "resume",       resume,       m_res);
      chk("R7",  "init_fire",    init_fire,    m_fire);
      chk("R7",  "init_law",     init_law,     m_law);
      chk("R7",  "init_en",      init_en,      m_en);
      chk("R7",  "init_mode",    init_mode,    m_mode);
      chk("R5",  "err_ce_early", err_ce_early, m_ee);
      chk("R8",  "err_slot",     err_slot,     m_es);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one slot: ce falls now with the given request and fields, lasts p clocks
  task automatic slot(input int p, input bit ir, input bit law, input bit en, input int mode);
    ce = 1'b0; init_req = ir; cfg_law = law; cfg_en = en; cfg_mode = 2'(mode);
    tick(p / 2);
    ce = 1'b1; init_req = 1'b0;
    tick(p - p / 2);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired got %0d expected below 20000", cycles);
      finish_run();
    end
  end

  initial begin
    por_n = 1'b0; rst_n = 1'b1; ce = 1'b0; init_req = 1'b0;
    cfg_law = 1'b0; cfg_en = 1'b0; cfg_mode = 2'd0;
    tick(3);
    chk("R9", "busy in power-on reset", busy, 1);
    chk("R9", "clr_en in power-on reset", clr_en, 0);
    por_n = 1'b1;
    tick(1);
    chk("R9", "clear starts after power-on", clr_en, 1);
    chk("R3", "first clear address", clr_addr, 0);
    tick(730);
    chk("R4", "still busy after clearing", busy, 1);
    ce = 1'b1; tick(3);
    ce = 1'b0; tick(1);
    chk("R4", "resume on first fall", resume, 1);
    chk("R4", "busy drops with resume", busy, 0);
    ce = 1'b1; tick(2);
    // R7 / R8: good request slot then a plain one
    slot(45, 1'b1, 1'b1, 1'b0, 2);
    slot(30, 1'b0, 1'b0, 1'b1, 3);
    chk("R8", "45-clock request slot accepted", err_slot, 0);
    chk("R7", "captured mode", init_mode, 3);
    slot(44, 1'b1, 1'b1, 1'b1, 1);
    slot(25, 1'b0, 1'b0, 1'b0, 0);
    chk("R8", "44-clock request slot flagged", err_slot, 1);
    // R2: one-edge glitch
    rst_n = 1'b0; tick(1);
    rst_n = 1'b1; tick(3);
    chk("R2", "glitch leaves busy low", busy, 0);
    chk("R2", "glitch keeps error flag", err_slot, 1);
    // R1: accepted reset
    ce = 1'b0; tick(2);
    rst_n = 1'b0; tick(2);
    chk("R1", "busy after accepted reset", busy, 1);
    chk("R1", "slot error cleared", err_slot, 0);
    chk("R1", "clr_en low in reset", clr_en, 0);
    rst_n = 1'b1;
    tick(6); ce = 1'b1; tick(1);
    chk("R5", "edge at sixth clock flagged", err_ce_early, 1);
    tick(20);
    for (int i = 0; i < 5; i++) begin
      ce = 1'b0; init_req = 1'b1; cfg_mode = 2'd2; tick(2);
      chk("R6", "no fire during clearing", init_fire, 0);
      chk("R4", "no resume during clearing", busy, 1);
      ce = 1'b1; tick(2);
    end
    ce = 1'b0; init_req = 1'b0;
    tick(720);
    // R5 boundary: seventh clock is allowed
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1;
    tick(7); ce = 1'b1; tick(1);
    chk("R5", "edge at seventh clock allowed", err_ce_early, 0);
    tick(730);
    ce = 1'b0; tick(1);
    chk("R4", "resume after second clear", resume, 1);
    ce = 1'b1; tick(2);
    slot(46, 1'b1, 1'b0, 1'b1, 1);
    slot(10, 1'b0, 1'b0, 1'b0, 0);
    chk("R8", "46-clock request slot flagged", err_slot, 1);
    // R9: power-on reset mid-run acts at once
    @(negedge clk);
    por_n = 1'b0;
    #1;
    chk("R9", "busy at once on power-on reset", busy, 1);
    chk("R9", "error cleared on power-on reset", err_slot, 0);
    tick(2);
    por_n = 1'b1;
    tick(740);
    finish_run();
  end

endmodule